// File: doc/BRIEF.md
# Serial EEPROM Write-Protection Controller

This block holds the write-guard state of a small serial EEPROM and rules on every write request before it reaches the array or the status register. It keeps a write-arm latch, a status-lock bit and a two-bit guard-size field. Decoded command strobes arrive from the serial front end. The block answers each status-register write or array write with a one-cycle accept or reject pulse. An accepted write holds the block busy until the cell-programming logic reports that the write is done.

The status-lock bit works together with an active-low protect pin. While the lock bit is set and the pin is low, the status register is frozen. Because the guard-size field cannot then be rewritten, the guarded address range is frozen too. A flag reports this hardware lock. The pin is synchronized inside the block. The array depth (1K or 2K bytes) is a parameter, and the guarded ranges scale with it.

Top module: `eeprom_wprot`

## Requirements
- R1: After reset, the status byte reads 0x00, the hardware-lock flag is 0, and no accept or reject pulse is produced.
- R2: While not busy, a write-enable strobe sets the arm bit (status bit 1), and a write-disable strobe clears it, in the cycle after the strobe.
- R3: With the lock bit (status bit 7) at 0, a status write made while armed is accepted at either level of the protect pin. Exactly one of accept or reject pulses for each write request, in the cycle after the request.
- R4: A status write made while not armed is rejected, and the status byte is unchanged.
- R5: With the lock bit at 1 and the protect pin high, a status write made while armed is accepted.
- R6: With the lock bit at 1 and the protect pin low, every status write is rejected even while armed, and no status bit changes.
- R7: The hardware-lock flag is 1 exactly when the lock bit is 1 and the synchronized pin is low. This holds whichever of the two conditions came first, and the flag falls once the pin returns high. The pin passes through two flops before it is used.
- R8: The guard field, status bits 3:2, selects the guarded addresses. 00 guards none, 01 guards the top quarter (600h–7FFh for 2K, 300h–3FFh for 1K), 10 guards the top half (400h–7FFh / 200h–3FFh), and 11 guards the whole array. An armed array write to a guarded address is rejected, and one to any other address is accepted.
- R9: An array write made while not armed is rejected.
- R10: An accepted write sets the busy bit (status bit 0) until a write-done strobe. On that strobe the busy bit clears, the arm bit clears, and an accepted status write commits data bit 7 to the lock bit and data bits 3:2 to the guard field.
- R11: A rejected write leaves the arm bit unchanged.
- R12: While busy, write requests are rejected, and the write-enable and write-disable strobes have no effect.
- R13: Status bits 6:4 always read 0, whatever data a status write carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWren | input | 1 | Write-enable command strobe |
| cmdWrdi | input | 1 | Write-disable command strobe |
| cmdWrsr | input | 1 | Status-register write request strobe |
| wrsrData | input | 8 | Data byte for a status-register write |
| cmdWrite | input | 1 | Array write request strobe |
| writeAddr | input | ADDR_W | Target byte address of an array write |
| writeData | input | 8 | Array write data; passes unchanged to the array path |
| writeDone | input | 1 | Programming-complete strobe from cell timing logic |
| protectN | input | 1 | Asynchronous active-low write-protect pin |
| acceptPulse | output | 1 | One-cycle pulse: request accepted |
| rejectPulse | output | 1 | One-cycle pulse: request rejected |
| statusByte | output | 8 | Status byte {lock,0,0,0,guard[1:0],arm,busy} |
| hwLockFlag | output | 1 | Hardware lock active |
| arrayData | output | 8 | Registered copy of the data of the last accepted array write |

## Verification
The assertions assume that at most one of the five command and done strobes is high in any cycle. That assumption is itself checked by an assertion, and the bench drives each strobe for exactly one cycle with idle cycles between them. The pin-dependent properties rely on the synchronized pin. For that reason the bench holds protect-pin changes for three cycles before it issues any request that depends on the pin. Write-done is pulsed only after an accepted write. The bench also applies one stray done while the block is idle, to show that such a strobe changes nothing.

// File: rtl/wp_pkg.sv
package wp_pkg;

  // Status byte bit positions (fixed by the host-visible format)
  localparam int unsigned ST_LOCK  = 7;
  localparam int unsigned ST_GRD_H = 3;
  localparam int unsigned ST_GRD_L = 2;
  localparam int unsigned ST_ARM   = 1;
  localparam int unsigned ST_BUSY  = 0;

  typedef enum logic [1:0] {
    GRD_NONE    = 2'b00,
    GRD_QUARTER = 2'b01,
    GRD_HALF    = 2'b10,
    GRD_ALL     = 2'b11
  } guardSel_t;

  typedef enum logic {
    PH_IDLE    = 1'b0,
    PH_PROGRAM = 1'b1
  } wpPhase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic armSet;
    logic armClr;
    logic loadPending;
    logic pendIsStatus;
    logic commit;
  } wpStrobe_t;

endpackage

// File: rtl/wp_sync.sv
module wp_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/wp_control.sv
module wp_control
  import wp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdWren,
  input  logic      cmdWrdi,
  input  logic      cmdWrsr,
  input  logic      cmdWrite,
  input  logic      writeDone,
  input  logic      armed,
  input  logic      lockBit,
  input  logic      pinHigh,
  input  logic      addrGuarded,
  output wpStrobe_t stb,
  output logic      busy,
  output logic      acceptPulse,
  output logic      rejectPulse
);
  wpPhase_t phase, phaseNext;
  logic     accNext, rejNext;
  logic     statusOpen;

  // R5/R6: status register writable unless locked with the pin low
  assign statusOpen = !(lockBit && !pinHigh);

  always_comb begin
    stb       = '0;
    phaseNext = phase;
    accNext   = 1'b0;
    rejNext   = 1'b0;
    unique case (phase)
      PH_PROGRAM: begin
        // R12: requests refused, enable/disable ignored while programming
        if (cmdWrsr || cmdWrite) rejNext = 1'b1;
        if (writeDone) begin
          // R10: completion clears arm and commits pending status data
          stb.armClr = 1'b1;
          stb.commit = 1'b1;
          phaseNext  = PH_IDLE;
        end
      end
      default: begin
        if (cmdWren) stb.armSet = 1'b1;   // R2
        if (cmdWrdi) stb.armClr = 1'b1;   // R2
        if (cmdWrsr) begin
          if (armed && statusOpen) begin  // R3 R4 R5 R6
            accNext          = 1'b1;
            stb.loadPending  = 1'b1;
            stb.pendIsStatus = 1'b1;
            phaseNext        = PH_PROGRAM;
          end else begin
            rejNext = 1'b1;               // R11: arm untouched
          end
        end
        if (cmdWrite) begin
          if (armed && !addrGuarded) begin // R8 R9
            accNext         = 1'b1;
            stb.loadPending = 1'b1;
            phaseNext       = PH_PROGRAM;
          end else begin
            rejNext = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      acceptPulse <= 1'b0;
      rejectPulse <= 1'b0;
    end else begin
      phase       <= phaseNext;
      acceptPulse <= accNext;
      rejectPulse <= rejNext;
    end
  end

  assign busy = (phase == PH_PROGRAM);
endmodule

// File: rtl/wp_datapath.sv
module wp_datapath
  import wp_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 2048,
  parameter int unsigned ADDR_W    = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  wpStrobe_t         stb,
  input  logic              busy,
  input  logic              newLock,
  input  logic [1:0]        newGuard,
  input  logic [ADDR_W-1:0] writeAddr,
  input  logic [7:0]        writeData,
  output logic              armed,
  output logic              lockBit,
  output logic              addrGuarded,
  output logic [7:0]        statusByte,
  output logic [7:0]        arrayData
);
  localparam int unsigned QUARTER_LO = MEM_BYTES - MEM_BYTES / 4;
  localparam int unsigned HALF_LO    = MEM_BYTES / 2;
  localparam logic [ADDR_W-1:0] QUARTER_BASE = ADDR_W'(QUARTER_LO);
  localparam logic [ADDR_W-1:0] HALF_BASE    = ADDR_W'(HALF_LO);

  guardSel_t guardQ;
  logic      armQ, lockQ;
  logic      pendStatusQ, pendLockQ;
  logic [1:0] pendGuardQ;

  // Arm latch: R2, R10
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           armQ <= 1'b0;
    else if (stb.armClr) armQ <= 1'b0;
    else if (stb.armSet) armQ <= 1'b1;
  end

  // Pending write capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendStatusQ <= 1'b0;
      pendLockQ   <= 1'b0;
      pendGuardQ  <= 2'b00;
      arrayData   <= 8'h00;
    end else if (stb.loadPending) begin
      pendStatusQ <= stb.pendIsStatus;
      if (stb.pendIsStatus) begin
        pendLockQ  <= newLock;
        pendGuardQ <= newGuard;
      end else begin
        arrayData <= writeData;
      end
    end
  end

  // Nonvolatile status fields, committed at completion: R10
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ  <= 1'b0;
      guardQ <= GRD_NONE;
    end else if (stb.commit && pendStatusQ) begin
      lockQ  <= pendLockQ;
      guardQ <= guardSel_t'(pendGuardQ);
    end
  end

  // Guarded range decode: R8
  always_comb begin
    unique case (guardQ)
      GRD_QUARTER: addrGuarded = (writeAddr >= QUARTER_BASE);
      GRD_HALF:    addrGuarded = (writeAddr >= HALF_BASE);
      GRD_ALL:     addrGuarded = 1'b1;
      default:     addrGuarded = 1'b0;
    endcase
  end

  // Status byte assembly: R13 keeps unused bits at zero
  always_comb begin
    statusByte           = 8'h00;
    statusByte[ST_LOCK]  = lockQ;
    statusByte[ST_GRD_H] = guardQ[1];
    statusByte[ST_GRD_L] = guardQ[0];
    statusByte[ST_ARM]   = armQ;
    statusByte[ST_BUSY]  = busy;
  end

  assign armed   = armQ;
  assign lockBit = lockQ;
endmodule

// File: rtl/eeprom_wprot.sv
module eeprom_wprot
  import wp_pkg::*;
#(
  parameter int unsigned MEM_BYTES   = 2048,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              cmdWrsr,
  input  logic [7:0]        wrsrData,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] writeAddr,
  input  logic [7:0]        writeData,
  input  logic              writeDone,
  input  logic              protectN,
  output logic              acceptPulse,
  output logic              rejectPulse,
  output logic [7:0]        statusByte,
  output logic              hwLockFlag,
  output logic [7:0]        arrayData
);
  wpStrobe_t stb;
  logic pinHigh, armed, lockBit, addrGuarded, busy;
  logic unusedWrsrBits;

  assign unusedWrsrBits = ^{wrsrData[6:4], wrsrData[1:0]};

  // R7: two-flop synchronizer on the protect pin
  wp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_pinSync (
    .clk(clk), .rstN(rstN), .asyncIn(protectN), .syncOut(pinHigh)
  );

  wp_control u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdWrsr(cmdWrsr),
    .cmdWrite(cmdWrite), .writeDone(writeDone),
    .armed(armed), .lockBit(lockBit), .pinHigh(pinHigh),
    .addrGuarded(addrGuarded),
    .stb(stb), .busy(busy),
    .acceptPulse(acceptPulse), .rejectPulse(rejectPulse)
  );

  wp_datapath #(.MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy),
    .newLock(wrsrData[ST_LOCK]), .newGuard(wrsrData[ST_GRD_H:ST_GRD_L]),
    .writeAddr(writeAddr), .writeData(writeData),
    .armed(armed), .lockBit(lockBit), .addrGuarded(addrGuarded),
    .statusByte(statusByte), .arrayData(arrayData)
  );

  // R7: lock active while lock bit set and synchronized pin low
  assign hwLockFlag = lockBit && !pinHigh;
endmodule

// File: rtl/eeprom_wprot_chk.sv
module eeprom_wprot_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdWren,
  input logic       cmdWrdi,
  input logic       cmdWrsr,
  input logic       cmdWrite,
  input logic       writeDone,
  input logic       acceptPulse,
  input logic       rejectPulse,
  input logic [7:0] statusByte,
  input logic       hwLockFlag
);
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdWren, cmdWrdi, cmdWrsr, cmdWrite, writeDone})); // R12

  AST_SINGLE_RESPONSE: assert property (@(posedge clk) disable iff (!rstN)
    !(acceptPulse && rejectPulse)); // R3

  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrsr || cmdWrite) |=> (acceptPulse || rejectPulse)); // R3

  AST_UNARMED_STATUS_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrsr && !statusByte[1]) |=> (rejectPulse && $stable(statusByte))); // R4

  AST_HWLOCK_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrsr && hwLockFlag) |=> (rejectPulse && $stable(statusByte))); // R6

  AST_HWLOCK_NEEDS_LOCKBIT: assert property (@(posedge clk) disable iff (!rstN)
    hwLockFlag |-> statusByte[7]); // R7

  AST_UNARMED_ARRAY_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && !statusByte[1]) |=> rejectPulse); // R9

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[0] && !writeDone) |=> statusByte[0]); // R10

  AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[0] && writeDone) |=> (!statusByte[1] && !statusByte[0])); // R10

  AST_REJECT_KEEPS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    rejectPulse |-> (statusByte[1] == $past(statusByte[1]))); // R11

  AST_ENABLE_SETS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWren && !statusByte[0]) |=> statusByte[1]); // R2

  AST_ZERO_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[6:4] == 3'b000); // R13
endmodule

bind eeprom_wprot eeprom_wprot_chk u_chk (
  .clk(clk), .rstN(rstN),
  .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdWrsr(cmdWrsr),
  .cmdWrite(cmdWrite), .writeDone(writeDone),
  .acceptPulse(acceptPulse), .rejectPulse(rejectPulse),
  .statusByte(statusByte), .hwLockFlag(hwLockFlag)
);

// File: tb/eeprom_wprot_tb.sv
`timescale 1ns/1ps
module eeprom_wprot_tb;
  localparam int unsigned MEM    = 2048;
  localparam int unsigned AW     = $clog2(MEM);
  localparam int unsigned QLO    = MEM - MEM / 4;
  localparam int unsigned HLO    = MEM / 2;
  localparam int unsigned TOP    = MEM - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWren = 0, cmdWrdi = 0, cmdWrsr = 0, cmdWrite = 0, writeDone = 0;
  logic [7:0] wrsrData = 8'h00;
  logic [AW-1:0] writeAddr = '0;
  logic [7:0] writeData = 8'h00;
  logic protectN = 1'b1;
  logic acceptPulse, rejectPulse, hwLockFlag;
  logic [7:0] statusByte, arrayData;

  always #2.5 clk = ~clk;

  eeprom_wprot #(.MEM_BYTES(MEM)) u_dut (
    .clk(clk), .rstN(rstN), .cmdWren(cmdWren), .cmdWrdi(cmdWrdi),
    .cmdWrsr(cmdWrsr), .wrsrData(wrsrData), .cmdWrite(cmdWrite),
    .writeAddr(writeAddr), .writeData(writeData), .writeDone(writeDone),
    .protectN(protectN), .acceptPulse(acceptPulse), .rejectPulse(rejectPulse),
    .statusByte(statusByte), .hwLockFlag(hwLockFlag), .arrayData(arrayData)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state, derived from the requirements
  bit mArm = 0, mLock = 0, mBusy = 0, mPinHigh = 1;
  bit [1:0] mGuard = 2'b00;
  bit pendStatus = 0, pendLock = 0;
  bit [1:0] pendGuard = 2'b00;

  bit    expQ[$];
  string tagQ[$];

  function automatic bit guarded(input int unsigned a, input bit [1:0] g);
    case (g)
      2'b01:   return a >= QLO;
      2'b10:   return a >= HLO;
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Monitor: pops expected responses as pulses appear
  always @(negedge clk) begin
    if (rstN && !finished && (acceptPulse || rejectPulse)) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected pulse acc=%0b rej=%0b expected none",
                 "R1", acceptPulse, rejectPulse);
      end else begin
        automatic bit    e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        if (acceptPulse !== e || rejectPulse !== !e) begin
          errors++;
          $display("FAIL %s: acc=%0b rej=%0b expected acc=%0b rej=%0b",
                   t, acceptPulse, rejectPulse, e, !e);
        end
      end
    end
  end

  task automatic checkStatus(input string tag);
    automatic bit [7:0] exp = {mLock, 3'b000, mGuard, mArm, mBusy};
    automatic bit expHw = mLock && !mPinHigh;
    @(negedge clk);
    checks++;
    if (statusByte !== exp || hwLockFlag !== expHw) begin
      errors++;
      $display("FAIL %s: status=%02h hw=%0b expected status=%02h hw=%0b",
               tag, statusByte, hwLockFlag, exp, expHw);
    end
  endtask

  task automatic doWren();
    @(negedge clk); cmdWren = 1;
    if (!mBusy) mArm = 1;
    @(negedge clk); cmdWren = 0;
  endtask

  task automatic doWrdi();
    @(negedge clk); cmdWrdi = 1;
    if (!mBusy) mArm = 0;
    @(negedge clk); cmdWrdi = 0;
  endtask

  task automatic doWrsr(input bit [7:0] d, input string tag);
    automatic bit ok = !mBusy && mArm && !(mLock && !mPinHigh);
    @(negedge clk);
    expQ.push_back(ok); tagQ.push_back(tag);
    wrsrData = d; cmdWrsr = 1;
    if (ok) begin
      mBusy = 1; pendStatus = 1; pendLock = d[7]; pendGuard = d[3:2];
    end
    @(negedge clk); cmdWrsr = 0;
  endtask

  task automatic doWrite(input int unsigned a, input string tag);
    automatic bit ok = !mBusy && mArm && !guarded(a, mGuard);
    @(negedge clk);
    expQ.push_back(ok); tagQ.push_back(tag);
    writeAddr = AW'(a); writeData = a[7:0] ^ 8'h5A; cmdWrite = 1;
    if (ok) begin
      mBusy = 1; pendStatus = 0;
    end
    @(negedge clk); cmdWrite = 0;
  endtask

  task automatic doDone();
    @(negedge clk); writeDone = 1;
    if (mBusy) begin
      if (pendStatus) begin mLock = pendLock; mGuard = pendGuard; end
      mArm = 0; mBusy = 0;
    end
    @(negedge clk); writeDone = 0;
  endtask

  task automatic setPin(input bit v);
    @(negedge clk); protectN = v; mPinHigh = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    checkStatus("R1");
    repeat (2) @(negedge clk);
    checkStatus("R1");

    doWrsr(8'h8C, "R4");             checkStatus("R4");
    doWren();                        checkStatus("R2");
    doWrdi();                        checkStatus("R2");
    doDone();                        checkStatus("R10"); // idle done: no change

    // Pin low first, then lock set through an accepted write
    setPin(0);
    doWren();
    doWrsr(8'h8C, "R3");             checkStatus("R10");
    doDone();                        checkStatus("R7");

    // Locked with pin low: rejected, arm kept
    doWren();
    doWrsr(8'h00, "R6");             checkStatus("R6");
    checkStatus("R11");

    // Release by pin high, then rewrite with lock=1 guard=01
    setPin(1);                       checkStatus("R7");
    doWrsr(8'h84, "R5");
    doDone();                        checkStatus("R5");
    setPin(0);                       checkStatus("R7"); // lock then pin

    // Quarter guard
    doWren();
    doWrite(QLO - 1, "R8");          doDone();
    doWren();
    doWrite(QLO, "R8");
    doWrite(TOP, "R8");              checkStatus("R11");
    doWrdi();
    doWrite(16, "R9");               checkStatus("R9");

    // Half guard, lock off
    setPin(1);
    doWren();
    doWrsr(8'h08, "R5");             doDone();
    doWren();
    doWrite(HLO - 1, "R8");          doDone();
    doWren();
    doWrite(HLO, "R8");

    // Busy behaviour
    doWrite(0, "R8");
    checkStatus("R10");
    doWrdi();                        checkStatus("R12");
    doWrite(1, "R12");
    doWrsr(8'h00, "R12");
    doWren();                        checkStatus("R12");
    doDone();                        checkStatus("R10");

    // Whole array, then none
    doWren();
    doWrsr(8'h0C, "R3");             doDone();
    doWren();
    doWrite(0, "R8");
    doWrsr(8'h00, "R3");             doDone();
    doWren();
    doWrite(TOP, "R8");              doDone();

    // Unused status bits
    doWren();
    doWrsr(8'hF3, "R13");            doDone();
    checkStatus("R13");
    setPin(0);
    doWren();
    doWrsr(8'h00, "R6");             checkStatus("R6");

    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R3: %0d responses missing expected 0", expQ.size());
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule